// File: doc/BRIEF.md
# Ethernet Pause Flow Controller

This block sequences transmit-side flow control for a full-duplex Ethernet MAC. Software writes a command bit plus two 16-bit settings: the pause quanta to advertise, and a refresh interval. When the command is set, the block asks the MAC transmitter for a pause control frame that carries the quanta, over a level request / acknowledge handshake. Once the frame is acknowledged, it measures time in slots of 512 bit times, derived from a per-bit-time strobe.

A nonzero refresh interval selects refresh mode. A new pause frame is requested each time the interval elapses, for as long as the command stays set. A zero refresh interval selects single mode. One frame is sent, the slot counter runs up to the quanta value, and the block then clears the command bit itself. If software drops the command, a final frame with quanta 0x0000 is requested to release the link partner. The live slot counter is exposed as a status value. Frame assembly, CRC, the MAC transmit path and register decoding are handled elsewhere.

Top module: `pause_flow_ctrl`

## Requirements
- R1: With `full_duplex` high, writing the command to 1 raises `pause_req` with `pause_value` equal to `quanta_cfg`. Exactly one frame is requested.
- R2: When software writes the command from 1 to 0 while a pause is running, one further request with `pause_value` = 0x0000 is made.
- R3: In refresh mode (`refresh_cfg` != 0), the slot counter clears when a frame is acknowledged and then advances once per 512 bit strobes. When it reaches `refresh_cfg`, a new request carrying `quanta_cfg` rises 512*`refresh_cfg`+1 clock cycles after the acknowledge cycle, provided `bit_tick` is high every cycle.
- R4: In single mode (`refresh_cfg` = 0), when the slot counter reaches `quanta_cfg`, `cmd_q` is cleared by hardware. No zero-quanta frame follows.
- R5: `status_cnt` shows the live slot counter, and is 0 whenever no pause interval is being timed, including after reset.
- R6: `pause_req` and `pause_value` are held until `pause_ack` is seen. The slot counter stays at 0 until the acknowledge.
- R7: If the command drops while a nonzero request is still unacknowledged, that request turns into the zero-quanta request, and only that one frame is sent. If the command is set again before the zero-quanta frame is acknowledged, a quanta frame follows it.
- R8: While `full_duplex` is low, no request is made and `status_cnt` stays 0.
- R9: `refresh_cfg` may change during a running pause. The running count is compared against the new target: `refresh_cfg` if nonzero, otherwise `quanta_cfg`. No reset is needed.
- R10: Slots are counted in `bit_tick` strobes, not clock cycles. A strobe at half rate doubles the refresh spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| full_duplex | input | 1 | Link runs in full duplex |
| cmd_wr_en | input | 1 | Software write strobe for the command bit |
| cmd_wr_val | input | 1 | Value written to the command bit |
| quanta_cfg | input | 16 | Pause quanta placed in frames |
| refresh_cfg | input | 16 | Refresh interval in slots; 0 selects single mode |
| bit_tick | input | 1 | One strobe per bit time |
| pause_ack | input | 1 | Transmitter accepted the requested frame |
| cmd_q | output | 1 | Current command bit (hardware may clear it) |
| pause_req | output | 1 | Pause frame request, level |
| pause_value | output | 16 | Quanta for the requested frame |
| status_cnt | output | 16 | Live slot counter |

## Verification
The bench aims at the handshake overlaps.
- A command dropped during a slow acknowledge must yield exactly one zero frame. A design that queued both frames would show up as an unexpected extra frame in the scoreboard.
- A command re-set during the zero frame must be followed by a quanta frame. A design that lost it would leave the expected queue non-empty.

The bench measures refresh spacing from the acknowledge, at full and half strobe rates. An off-by-one in the prescaler, or counting that starts before the acknowledge, moves the request edge outside the allowed window.

Single-mode expiry is checked for the hardware clear and for the absence of a trailing zero frame. The same checks are repeated after switching modes mid-pause, which catches a design that kept comparing against the old target.

// File: rtl/pause_fc_pkg.sv
package pause_fc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_REQ_ON  = 2'd1,
    ST_RUN     = 2'd2,
    ST_REQ_OFF = 2'd3
  } fc_state_e;
endpackage

// File: rtl/pause_tick_prescaler.sv
module pause_tick_prescaler #(
  parameter int PRE_W = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bit_tick,
  output logic slot_tick
);
  localparam logic [PRE_W-1:0] PRE_MAX = {PRE_W{1'b1}};

  logic [PRE_W-1:0] pre_q, pre_d;
  logic             pre_en;

  assign pre_en    = clear | bit_tick;
  assign slot_tick = !clear && bit_tick && (pre_q == PRE_MAX);

  always_comb begin
    pre_d = pre_q;
    if (clear)         pre_d = '0;
    else if (bit_tick) pre_d = pre_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (pre_en) pre_q <= pre_d;
  end

  // R10: a slot strobe is never produced on two consecutive cycles
  p_slot_spacing_r10: assert property (@(posedge clk) disable iff (!rst_n)
    slot_tick |=> !slot_tick);
endmodule

// File: rtl/pause_slot_counter.sv
module pause_slot_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [CNT_W-1:0] target,
  output logic [CNT_W-1:0] count,
  output logic             reached
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en  = clear | step;
  assign count   = cnt_q;
  assign reached = (cnt_q >= target);

  always_comb begin
    cnt_d = cnt_q;
    if (clear)     cnt_d = '0;
    else if (step) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R3: the counter only ever advances by one or returns to zero
  p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> ((cnt_q == $past(cnt_q) + CNT_W'(1)) || (cnt_q == '0)));
endmodule

// File: rtl/pause_seq_fsm.sv
module pause_seq_fsm
  import pause_fc_pkg::*;
#(
  parameter int QW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          full_duplex,
  input  logic          cmd_wr_en,
  input  logic          cmd_wr_val,
  input  logic [QW-1:0] quanta_cfg,
  input  logic          single_mode,
  input  logic          interval_hit,
  input  logic          pause_ack,
  output logic          cmd_q,
  output logic          pause_req,
  output logic [QW-1:0] pause_value,
  output logic          running
);
  fc_state_e     state_q, state_d;
  logic          cmd_d, hw_clear;
  logic [QW-1:0] val_q, val_d;
  logic          val_en;

  always_comb begin
    state_d  = state_q;
    hw_clear = 1'b0;
    unique case (state_q)
      ST_IDLE:    if (cmd_q) state_d = ST_REQ_ON;
      ST_REQ_ON: begin
        if (!cmd_q)         state_d = ST_REQ_OFF;
        else if (pause_ack) state_d = ST_RUN;
      end
      ST_RUN: begin
        if (!cmd_q) state_d = ST_REQ_OFF;
        else if (interval_hit) begin
          if (single_mode) begin
            state_d  = ST_IDLE;
            hw_clear = 1'b1;
          end else begin
            state_d  = ST_REQ_ON;
          end
        end
      end
      ST_REQ_OFF: if (pause_ack) state_d = cmd_q ? ST_REQ_ON : ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
    if (!full_duplex) begin
      state_d  = ST_IDLE;
      hw_clear = 1'b0;
    end
  end

  // software write wins over the hardware clear
  always_comb begin
    cmd_d = cmd_q;
    if (cmd_wr_en)     cmd_d = cmd_wr_val;
    else if (hw_clear) cmd_d = 1'b0;
  end

  always_comb begin
    val_d  = val_q;
    val_en = 1'b0;
    if (state_d == ST_REQ_OFF) begin
      val_d  = '0;
      val_en = 1'b1;
    end else if (state_d == ST_REQ_ON && state_q != ST_REQ_ON) begin
      val_d  = quanta_cfg;
      val_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cmd_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_q <= '0;
    else if (val_en) val_q <= val_d;
  end

  assign pause_req   = (state_q == ST_REQ_ON) || (state_q == ST_REQ_OFF);
  assign pause_value = val_q;
  assign running     = (state_q == ST_RUN) && (state_d == ST_RUN);

  // R6: an unacknowledged request stays up while the link is full duplex
  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_req && !pause_ack && full_duplex) |=> pause_req);

  // R7: a waiting request keeps its value unless it is replaced by zero
  p_value_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_req && !pause_ack && full_duplex) |=>
      ((pause_value == $past(pause_value)) || (pause_value == '0)));

  // R2: dropping the command during a running pause requests a zero frame
  p_zero_on_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cmd_q) && state_q == ST_RUN && full_duplex) |=>
      (pause_req && pause_value == '0));

  // R4: a hardware clear of the command is not followed by a request
  p_no_frame_after_expiry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cmd_q) && !$past(cmd_wr_en)) |=> !pause_req);
endmodule

// File: rtl/pause_flow_ctrl.sv
module pause_flow_ctrl #(
  parameter int QUANTA_W   = 16,
  parameter int PRESCALE_W = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                full_duplex,
  input  logic                cmd_wr_en,
  input  logic                cmd_wr_val,
  input  logic [QUANTA_W-1:0] quanta_cfg,
  input  logic [QUANTA_W-1:0] refresh_cfg,
  input  logic                bit_tick,
  input  logic                pause_ack,
  output logic                cmd_q,
  output logic                pause_req,
  output logic [QUANTA_W-1:0] pause_value,
  output logic [QUANTA_W-1:0] status_cnt
);
  logic                single_mode;
  logic [QUANTA_W-1:0] slot_target;
  logic                running, slot_tick, interval_hit;

  assign single_mode = (refresh_cfg == '0);
  assign slot_target = single_mode ? quanta_cfg : refresh_cfg;

  pause_seq_fsm #(.QW(QUANTA_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .full_duplex  (full_duplex),
    .cmd_wr_en    (cmd_wr_en),
    .cmd_wr_val   (cmd_wr_val),
    .quanta_cfg   (quanta_cfg),
    .single_mode  (single_mode),
    .interval_hit (interval_hit),
    .pause_ack    (pause_ack),
    .cmd_q        (cmd_q),
    .pause_req    (pause_req),
    .pause_value  (pause_value),
    .running      (running)
  );

  pause_tick_prescaler #(.PRE_W(PRESCALE_W)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (!running),
    .bit_tick  (bit_tick),
    .slot_tick (slot_tick)
  );

  pause_slot_counter #(.CNT_W(QUANTA_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (!running),
    .step    (slot_tick),
    .target  (slot_target),
    .count   (status_cnt),
    .reached (interval_hit)
  );

  // R8: half duplex withdraws requests and zeroes the status
  p_half_duplex_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !full_duplex |=> (!pause_req && status_cnt == '0));

  // R6: the counter does not move while a frame is being requested
  p_no_count_while_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pause_req |-> status_cnt == '0);
endmodule

// File: tb/tb_pause_flow_ctrl.sv
module tb_pause_flow_ctrl;
  logic        clk, rst_n;
  logic        full_duplex, cmd_wr_en, cmd_wr_val, bit_tick, pause_ack;
  logic [15:0] quanta_cfg, refresh_cfg;
  logic        cmd_q, pause_req;
  logic [15:0] pause_value, status_cnt;

  int checks = 0, errors = 0;
  int cyc = 0, ack_cyc = 0, ack_count = 0, ack_delay = 3;
  int exp_gap = -1, gap_tol = 1;
  string gap_tag = "R3";
  bit tick_half = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];

  pause_flow_ctrl dut (
    .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex),
    .cmd_wr_en(cmd_wr_en), .cmd_wr_val(cmd_wr_val),
    .quanta_cfg(quanta_cfg), .refresh_cfg(refresh_cfg),
    .bit_tick(bit_tick), .pause_ack(pause_ack),
    .cmd_q(cmd_q), .pause_req(pause_req),
    .pause_value(pause_value), .status_cnt(status_cnt)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expect_frame(input logic [15:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cmd(input bit v);
    @(negedge clk);
    cmd_wr_en = 1'b1; cmd_wr_val = v;
    @(negedge clk);
    cmd_wr_en = 1'b0;
  endtask

  task automatic wait_acks(input int n);
    wait (ack_count >= n);
    @(negedge clk);
  endtask

  // bit strobe: every cycle, or every other cycle
  initial begin
    bit_tick = 1'b1;
    forever begin
      @(negedge clk);
      bit_tick = tick_half ? ~bit_tick : 1'b1;
    end
  end

  // transmitter model and scoreboard monitor
  initial begin
    int  wcnt = 0;
    bit  prev_req = 0;
    logic [15:0] e;
    string t;
    pause_ack = 1'b0;
    forever begin
      @(negedge clk);
      if (pause_ack) begin
        pause_ack = 1'b0;
        ack_cyc   = cyc;
        ack_count++;
        wcnt = 0;
      end else if (pause_req && rst_n) begin
        if (!prev_req && exp_gap >= 0) begin
          chk((cyc - ack_cyc >= exp_gap - gap_tol) && (cyc - ack_cyc <= exp_gap + gap_tol),
              {gap_tag, " request spacing"}, cyc - ack_cyc, exp_gap);
        end
        wcnt++;
        if (wcnt >= ack_delay) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R2/R4 unexpected frame", int'(pause_value), -1);
          end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(pause_value == e, {t, " frame value"}, int'(pause_value), int'(e));
          end
          pause_ack = 1'b1;
        end
      end else begin
        wcnt = 0;
      end
      prev_req = pause_req;
    end
  end

  // watchdog
  initial begin
    wait (cyc > 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; full_duplex = 1'b1; cmd_wr_en = 1'b0; cmd_wr_val = 1'b0;
    quanta_cfg = 16'h0100; refresh_cfg = 16'd2;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(2);
    // R5: reset state
    chk(!pause_req, "R5 reset req", pause_req, 0);
    chk(status_cnt == 0, "R5 reset status", status_cnt, 0);
    chk(!cmd_q, "R5 reset cmd", cmd_q, 0);

    // R8: half duplex blocks requests
    full_duplex = 1'b0;
    set_cmd(1);
    wait_cyc(200);
    chk(ack_count == 0, "R8 no frame in half duplex", ack_count, 0);
    chk(status_cnt == 0, "R8 status in half duplex", status_cnt, 0);
    set_cmd(0);
    wait_cyc(5);
    full_duplex = 1'b1;

    // R1/R3: refresh mode, quanta 0x0100, interval 2
    n = ack_count;
    expect_frame(16'h0100, "R1"); expect_frame(16'h0100, "R3"); expect_frame(16'h0100, "R3");
    set_cmd(1);
    wait_acks(n + 1);
    exp_gap = 512 * 2 + 1; gap_tag = "R3";
    wait_cyc(512 + 256);
    chk(status_cnt == 1, "R5 live count in refresh mode", status_cnt, 1);
    wait_acks(n + 3);
    exp_gap = -1;
    wait_cyc(100);
    // R2: drop produces zero frame
    expect_frame(16'h0000, "R2");
    set_cmd(0);
    wait_acks(n + 4);
    wait_cyc(50);
    chk(ack_count == n + 4 && !pause_req, "R2 single zero frame", ack_count, n + 4);

    // R4: single mode, quanta 3
    refresh_cfg = 16'd0; quanta_cfg = 16'd3;
    n = ack_count;
    expect_frame(16'd3, "R4");
    set_cmd(1);
    wait_acks(n + 1);
    wait_cyc(512 + 256);
    chk(status_cnt == 1, "R5 live count in single mode", status_cnt, 1);
    wait_cyc(760);
    chk(cmd_q, "R4 command still set before expiry", cmd_q, 1);
    wait_cyc(14);
    chk(!cmd_q, "R4 command cleared on expiry", cmd_q, 0);
    wait_cyc(600);
    chk(ack_count == n + 1, "R4 no zero frame after expiry", ack_count, n + 1);
    chk(status_cnt == 0, "R5 status idle after expiry", status_cnt, 0);

    // R7: drop during slow acknowledge replaces the request
    quanta_cfg = 16'h0200;
    n = ack_count;
    ack_delay = 40;
    expect_frame(16'h0000, "R7");
    set_cmd(1);
    wait_cyc(5);
    chk(pause_req && status_cnt == 0, "R6 no count before ack", status_cnt, 0);
    set_cmd(0);
    wait_acks(n + 1);
    wait_cyc(60);
    chk(ack_count == n + 1, "R7 only the zero frame", ack_count, n + 1);
    // R7: re-set during zero frame
    ack_delay = 3;
    expect_frame(16'h0200, "R7");
    set_cmd(1);
    wait_acks(n + 2);
    ack_delay = 40;
    expect_frame(16'h0000, "R7"); expect_frame(16'h0200, "R7");
    set_cmd(0);
    wait_cyc(10);
    set_cmd(1);
    wait_acks(n + 4);
    ack_delay = 3;
    wait_cyc(20);
    chk(cmd_q && !pause_req, "R7 running after re-set", cmd_q, 1);
    expect_frame(16'h0000, "R2");
    set_cmd(0);
    wait_acks(n + 5);

    // R9: nonzero to zero refresh mid-pause
    refresh_cfg = 16'd4; quanta_cfg = 16'd2;
    n = ack_count;
    expect_frame(16'd2, "R9");
    set_cmd(1);
    wait_acks(n + 1);
    wait_cyc(600);
    refresh_cfg = 16'd0;
    wait_cyc(400);
    chk(cmd_q, "R9 still running before new target", cmd_q, 1);
    wait_cyc(40);
    chk(!cmd_q, "R9 expiry at quanta after switch", cmd_q, 0);
    wait_cyc(100);
    chk(ack_count == n + 1, "R9 no frame after expiry", ack_count, n + 1);

    // R9: zero to nonzero refresh mid-pause
    quanta_cfg = 16'd5;
    n = ack_count;
    expect_frame(16'd5, "R9");
    set_cmd(1);
    wait_acks(n + 1);
    exp_gap = 512 * 2 + 1; gap_tag = "R9";
    wait_cyc(100);
    refresh_cfg = 16'd2;
    expect_frame(16'd5, "R9");
    wait_acks(n + 2);
    exp_gap = -1;
    expect_frame(16'h0000, "R2");
    set_cmd(0);
    wait_acks(n + 3);

    // R10: half-rate bit strobe doubles the spacing
    tick_half = 1;
    refresh_cfg = 16'd1; quanta_cfg = 16'd9;
    n = ack_count;
    expect_frame(16'd9, "R10"); expect_frame(16'd9, "R10");
    set_cmd(1);
    wait_acks(n + 1);
    exp_gap = 1024 + 1; gap_tol = 2; gap_tag = "R10";
    wait_acks(n + 2);
    exp_gap = -1;
    expect_frame(16'h0000, "R2");
    set_cmd(0);
    wait_acks(n + 3);
    tick_half = 0;

    wait_cyc(20);
    chk(exp_q.size() == 0, "R1 all expected frames seen", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule